// File: doc/BRIEF.md
# Vector Pairwise Lane Adder

This unit forms a double-width word from two vector sources, with the second source above the first. It then adds neighbouring lanes of that word in pairs. Each result lane is the wrapped sum of one pair, so the result has as many lanes as one source. The low half of the result comes from pairs taken inside the first source, and the high half from pairs taken inside the second.

A two-bit size code sets the lane width, and a width flag sets the data width to 64 or 128 bits. A narrow operation reads only the low 64 bits of each source and clears the upper half of the result. One combination of code and flag is reserved: the unit raises a flag for it and forces a zero result.

Operands and control are captured when `in_valid` is high. Result, flag and `out_valid` appear one clock later.

Top module: `vec_pair_add`

## Requirements
- R1: Lane width is 8 shifted left by `lane_sz` (00=8, 01=16, 10=32, 11=64 bits). With `wide`=1 (128-bit data), result lane e equals lane 2e plus lane 2e+1 of the 256-bit word {opnd_b, opnd_a}, so result[63:0] holds the pair sums of opnd_a and result[127:64] holds those of opnd_b.
- R2: Every lane sum wraps modulo 2 to the power of the lane width; no carry crosses into a neighbouring lane.
- R3: With `wide`=0 (64-bit data) the pairing uses only opnd_a[63:0] and opnd_b[63:0]: result[31:0] holds the pair sums from A, result[63:32] those from B, and result[127:64] is zero; operand bits 127:64 have no effect.
- R4: `lane_sz`=11 with `wide`=0 is reserved: `illegal` is 1 and `result` is all zero for that operation.
- R5: Every other combination of `lane_sz` and `wide` gives `illegal`=0.
- R6: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1, and `result` and `illegal` for that operation appear in that same cycle.
- R7: While `in_valid` is 0, `result` and `illegal` keep their values whatever the other inputs do.
- R8: After reset `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Capture operands and control this cycle |
| wide | input | 1 | 1 = 128-bit data, 0 = 64-bit data |
| lane_sz | input | 2 | Lane width code: 8 shifted left by this value |
| opnd_a | input | 128 | First source (lower half of the paired word) |
| opnd_b | input | 128 | Second source (upper half of the paired word) |
| out_valid | output | 1 | Result of the captured operation is present |
| result | output | 128 | Pairwise sums |
| illegal | output | 1 | Captured operation used the reserved encoding |

## Verification
The assertions check every cycle that `out_valid` follows `in_valid` by one clock, that a reserved operation yields the flag and a zero result, and that legal operations never raise it. They also check that a narrow operation leaves the upper 64 result bits clear and that held outputs stay still while `in_valid` is low. The bench compares each value against a reference model built from loops. This covers the arithmetic: correct lane pairing, which half each source lands in, wraparound at the boundary patterns, and that high operand bits are ignored in narrow mode. The assertions do not check any of these.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

  typedef enum logic [1:0] {
    LSZ_8  = 2'b00,
    LSZ_16 = 2'b01,
    LSZ_32 = 2'b10,
    LSZ_64 = 2'b11
  } lane_sz_e;

  localparam int unsigned NUM_LANE_SZ = 4;

  // Reserved: 64-bit lanes on 64-bit data (only one pair would remain).
  function automatic logic mode_reserved(input logic wide_f, input logic [1:0] sz);
    return (!wide_f) && (sz == LSZ_64);
  endfunction

  // Lane width in bits for a size code.
  function automatic int unsigned lane_bits(input logic [1:0] sz);
    return 32'd8 << sz;
  endfunction

endpackage

// File: rtl/vpa_mode_decode.sv
module vpa_mode_decode
  import vpa_pkg::*;
(
  input  logic       wide,
  input  logic [1:0] lane_sz,
  output logic       reserved_o,
  output logic       narrow_o
);
  always_comb begin
    reserved_o = mode_reserved(wide, lane_sz);
    narrow_o   = !wide;
  end
endmodule

// File: rtl/vpa_pair_bank.sv
module vpa_pair_bank #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0]   vec_i,
  output logic [DATA_W/2-1:0] fold_o
);
  localparam int unsigned NPAIR = DATA_W / (2 * LANE_W);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [LANE_W-1:0] lo_lane;
    logic [LANE_W-1:0] hi_lane;
    assign lo_lane = vec_i[(2*p)*LANE_W +: LANE_W];
    assign hi_lane = vec_i[(2*p+1)*LANE_W +: LANE_W];
    assign fold_o[p*LANE_W +: LANE_W] = lo_lane + hi_lane;
  end
endmodule

// File: rtl/vpa_out_stage.sv
module vpa_out_stage #(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              reserved_i,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= load_i;
      if (load_i) begin
        illegal <= reserved_i;
        result  <= reserved_i ? '0 : sum_i;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> out_valid);  // R6
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> !out_valid);  // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(result) && $stable(illegal)));  // R7
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (result == '0));  // R4
endmodule

// File: rtl/vec_pair_add.sv
module vec_pair_add
  import vpa_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              wide,
  input  logic [1:0]        lane_sz,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned QTR_W  = DATA_W / 4;

  logic              reserved_w;
  logic              narrow_w;
  logic [HALF_W-1:0] fold_a [NUM_LANE_SZ];
  logic [HALF_W-1:0] fold_b [NUM_LANE_SZ];
  logic [HALF_W-1:0] sel_a;
  logic [HALF_W-1:0] sel_b;
  logic [DATA_W-1:0] sum_w;

  vpa_mode_decode u_dec (
    .wide       (wide),
    .lane_sz    (lane_sz),
    .reserved_o (reserved_w),
    .narrow_o   (narrow_w)
  );

  // One adder bank per lane width; the size code picks one.
  for (genvar k = 0; k < NUM_LANE_SZ; k++) begin : g_sz
    vpa_pair_bank #(.DATA_W(DATA_W), .LANE_W(8 << k)) u_bank_a (
      .vec_i  (opnd_a),
      .fold_o (fold_a[k])
    );
    vpa_pair_bank #(.DATA_W(DATA_W), .LANE_W(8 << k)) u_bank_b (
      .vec_i  (opnd_b),
      .fold_o (fold_b[k])
    );
  end

  assign sel_a = fold_a[lane_sz];
  assign sel_b = fold_b[lane_sz];

  // Pairs of the low 64 source bits land in the low quarter of each fold.
  always_comb begin
    if (narrow_w) sum_w = {{HALF_W{1'b0}}, sel_b[QTR_W-1:0], sel_a[QTR_W-1:0]};
    else          sum_w = {sel_b, sel_a};
  end

  vpa_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (in_valid),
    .sum_i      (sum_w),
    .reserved_i (reserved_w),
    .out_valid  (out_valid),
    .result     (result),
    .illegal    (illegal)
  );

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[DATA_W-1:HALF_W] == '0));  // R3
  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide && lane_sz == 2'b11) |=> illegal);  // R4
  AST_LEGAL_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (wide || lane_sz != 2'b11)) |=> !illegal);  // R5
endmodule

// File: tb/tb_vec_pair_add.sv
module tb_vec_pair_add;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         wide = 1'b0;
  logic [1:0]   lane_sz = 2'b00;
  logic [127:0] opnd_a = '0;
  logic [127:0] opnd_b = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vec_pair_add dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide),
    .lane_sz(lane_sz), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  // {opnd_b, opnd_a}
  localparam logic [255:0] PATS [8] = '{
    {128'h0, 128'h0},
    {{16{8'h7F}}, {16{8'h7F}}},
    {{16{8'h80}}, {16{8'h80}}},
    {{16{8'hFF}}, {16{8'hFF}}},
    {{16{8'h80}}, {16{8'h7F}}},
    {{8{16'h7FFF}}, {8{16'h8000}}},
    {128'h0123456789ABCDEF_FEDCBA9876543210, 128'hDEADBEEF_CAFEF00D_13579BDF_2468ACE0},
    {128'h8000000000000000_FFFFFFFFFFFFFFFF, 128'h7FFFFFFF80000000_0000000100000001}
  };

  function automatic logic [127:0] ref_sum(input logic [127:0] a, input logic [127:0] b,
                                           input logic w, input logic [1:0] s);
    logic [255:0] cat;
    logic [127:0] acc;
    logic [255:0] msk;
    int lw, ds, n;
    if (!w && s == 2'b11) return '0;
    ds  = w ? 128 : 64;
    lw  = 8 << s;
    n   = ds / lw;
    cat = w ? {b, a} : {128'h0, b[63:0], a[63:0]};
    msk = (256'h1 << lw) - 256'h1;
    acc = '0;
    for (int e = 0; e < n; e++) begin
      logic [255:0] x0, x1, t;
      x0 = (cat >> (2 * e * lw)) & msk;
      x1 = (cat >> ((2 * e + 1) * lw)) & msk;
      t  = ((x0 + x1) & msk) << (e * lw);
      acc = acc | t[127:0];
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [127:0] a, input logic [127:0] b,
                       input logic w, input logic [1:0] s);
    @(negedge clk);
    opnd_a = a; opnd_b = b; wide = w; lane_sz = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input logic [127:0] a, input logic [127:0] b,
                         input logic w, input logic [1:0] s);
    logic rsv;
    rsv = !w && s == 2'b11;
    issue(a, b, w, s);
    check("R6 out_valid", {127'h0, out_valid}, 128'h1);
    check(rsv ? "R4 illegal" : "R5 illegal", {127'h0, illegal}, {127'h0, rsv});
    check(rsv ? "R4 result" : (w ? "R1 R2 result" : "R3 result"), result, ref_sum(a, b, w, s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (2) @(negedge clk);
    // R8: reset state
    check("R8 out_valid", {127'h0, out_valid}, 128'h0);
    check("R8 illegal", {127'h0, illegal}, 128'h0);
    check("R8 result", result, 128'h0);
    rst_n = 1'b1;

    // Table walk over every width and size code (R1 R2 R3 R4 R5 R6)
    for (int p = 0; p < 8; p++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 4; s++)
          run_one(PATS[p][127:0], PATS[p][255:128], w[0], s[1:0]);

    // R2: explicit wrap in an 8-bit lane, no carry into lane 1
    issue(128'h0000_0000_0000_0000_0000_0000_0000_01FF, 128'h0, 1'b1, 2'b00);
    check("R2 wrap", result, 128'h0);

    // R1: lane placement, 16-bit lanes, A low half, B high half
    issue(128'h0008_0007_0006_0005_0004_0003_0002_0001,
          128'h0010_000F_000E_000D_000C_000B_000A_0009, 1'b1, 2'b01);
    check("R1 placement", result, 128'h001F_001B_0017_0013_000F_000B_0007_0003);

    // R3: upper operand bits ignored in 64-bit mode
    issue({64'hFFFF_0000_AAAA_5555, 64'h0001_0002_0003_0004},
          {64'h1234_5678_9ABC_DEF0, 64'h0010_0020_0030_0040}, 1'b0, 2'b01);
    check("R3 ignore upper", result, {64'h0, 32'h0030_0070, 32'h0003_0007});

    // R7: hold while in_valid is low
    held = result;
    @(negedge clk);
    opnd_a = '1; opnd_b = '1; wide = 1'b0; lane_sz = 2'b11;
    repeat (3) @(negedge clk);
    check("R7 hold result", result, held);
    check("R7 hold illegal", {127'h0, illegal}, 128'h0);
    check("R6 no valid", {127'h0, out_valid}, 128'h0);

    // R4 then back-to-back legal: flag clears
    run_one('1, '1, 1'b0, 2'b11);
    run_one('1, '1, 1'b1, 2'b11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule